// File: doc/BRIEF.md
# Parallel Panel Command Bus Master

This block drives command traffic to display panels that keep their own frame memory and take register and pixel traffic over a parallel strobed bus. Software programs a command word, then launches one bus cycle by writing a start register. The start register also selects which of two panels, main or sub, is addressed. Three kinds of cycle exist: an index write, a data write and a data read.

Each cycle runs through three timed phases: address setup, strobe low, and hold. The length of each phase is a parameter in clock cycles. While a cycle runs, a busy flag is high, both on a pin and in the status register. Software polls it before the next access. A read samples the panel's 18-bit bus when the read strobe rises, and the sampled value is kept for software.

Register map (word index on `reg_addr`): 0 command word, 1 read request / read result, 2 write-start, 3 read-start, 4 status.

Top module: `panel_cmd_master`

## Requirements
- R1: After reset, busy is 0, both chip selects and both strobes are high (inactive), the bus output enable is 0 and the status register (index 4) reads 0.
- R2: Writing the write-start register (index 2) with bit 0 = 1 while idle, when the command word has bit 28 = 1, launches a write cycle. Bit 1 of that write selects the panel: 1 drives only `cs_sub_n` low for the whole cycle, and 0 drives only `cs_main_n` low.
- R3: During a write cycle, `rs` equals command bit 24 (1 = data, 0 = index). `bus_out` carries command bits 17:0, and `bus_oe` is 1.
- R4: A cycle holds busy for SETUP_CYC + STROBE_CYC + HOLD_CYC clocks. The strobe is high in the first SETUP_CYC clocks, low for STROBE_CYC clocks, then high for HOLD_CYC clocks. Status bit 1 reads 1 while busy. The two strobes are never low together.
- R5: A write-start with bit 0 = 0, or with command bit 28 = 0, starts nothing.
- R6: A start written while busy, including in the last hold clock, is ignored. A start written once busy has dropped is accepted.
- R7: The command word and panel choice are captured at launch. Rewriting the command register during a cycle does not change the running cycle.
- R8: Writing index 1 with bit 24 = 1 arms a read. A read-start (index 3, bit 0 = 1, bit 1 = panel) then launches a read cycle with `rs` = 1 and `bus_oe` = 0 throughout. Launching the read consumes the arming, and a read-start without arming is ignored.
- R9: The value on `bus_in` during the final strobe-low clock of a read is captured. Index 1 then reads it in bits 17:0, with bits 31:18 zero, and the value stays until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy | output | 1 | Bus cycle in progress |
| cs_main_n | output | 1 | Main panel chip select, active low |
| cs_sub_n | output | 1 | Sub panel chip select, active low |
| rs | output | 1 | Register select: 1 data, 0 index |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| bus_out | output | 18 | Panel bus drive value |
| bus_oe | output | 1 | Panel bus output enable |
| bus_in | input | 18 | Panel bus sampled value |

## Verification
Two things can meet in one clock: a cycle ending in its last hold clock, and a new start command from software. The bench times a write-start so that it is sampled at the very edge where the hold phase ends. It then checks that busy drops and that only one strobe pulse appeared. A start issued one clock later must launch a fresh cycle. A second collision is a command-register rewrite landing mid-cycle. It is judged by the value on the bus during the strobe.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned PCB_DW     = 18;
  localparam int unsigned PCB_AW     = 3;
  localparam int unsigned PCB_RW     = 32;

  localparam logic [PCB_AW-1:0] A_CMD  = 3'd0;
  localparam logic [PCB_AW-1:0] A_RDAT = 3'd1;
  localparam logic [PCB_AW-1:0] A_WGO  = 3'd2;
  localparam logic [PCB_AW-1:0] A_RGO  = 3'd3;
  localparam logic [PCB_AW-1:0] A_STAT = 3'd4;

  localparam int unsigned B_WRFLAG = 28;
  localparam int unsigned B_DSEL   = 24;
  localparam int unsigned B_ARM    = 24;
  localparam int unsigned B_GO     = 0;
  localparam int unsigned B_CHAN   = 1;
  localparam int unsigned B_BUSY   = 1;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic              is_read;
    logic              sub;
    logic              rs;
    logic [PCB_DW-1:0] val;
  } op_t;
endpackage

// File: rtl/pcb_regs.sv
module pcb_regs
  import pcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PCB_AW-1:0] addr,
  input  logic              wr,
  input  logic [PCB_RW-1:0] wdata,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [PCB_DW-1:0] cap_data,
  output logic              launch,
  output op_t               op_new,
  output logic [PCB_RW-1:0] rdata
);
  localparam int unsigned PAD_W = PCB_RW - PCB_DW;

  logic [PCB_RW-1:0] cmd_q, cmd_d;
  logic              arm_q, arm_d;
  logic [PCB_DW-1:0] res_q, res_d;
  logic              wgo_hit, rgo_hit;

  always_comb begin
    wgo_hit = wr && (addr == A_WGO) && wdata[B_GO] && !busy && cmd_q[B_WRFLAG];
    rgo_hit = wr && (addr == A_RGO) && wdata[B_GO] && !busy && arm_q;
    launch  = wgo_hit || rgo_hit;

    op_new.is_read = rgo_hit;
    op_new.sub     = wdata[B_CHAN];
    op_new.rs      = rgo_hit ? 1'b1 : cmd_q[B_DSEL];
    op_new.val     = cmd_q[PCB_DW-1:0];
  end

  always_comb begin
    cmd_d = cmd_q;
    if (wr && (addr == A_CMD)) cmd_d = wdata;

    arm_d = arm_q;
    if (wr && (addr == A_RDAT)) arm_d = wdata[B_ARM];
    else if (rgo_hit)           arm_d = 1'b0;

    res_d = res_q;
    if (cap_en) res_d = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      arm_q <= 1'b0;
      res_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      arm_q <= arm_d;
      res_q <= res_d;
    end
  end

  always_comb begin
    case (addr)
      A_CMD:   rdata = cmd_q;
      A_RDAT:  rdata = {{PAD_W{1'b0}}, res_q};
      A_STAT:  rdata = PCB_RW'(busy) << B_BUSY;
      default: rdata = '0;
    endcase
  end

  // R8: a launched read uses up its arming
  p_arm_consumed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rgo_hit) |-> !arm_q);

  // R9: capture only happens inside a running cycle
  p_capture_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> busy);
endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   launch,
  input  op_t    op_new,
  output phase_e phase,
  output op_t    op_cur,
  output logic   busy,
  output logic   cap_en
);
  localparam int unsigned MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last;
  op_t               op_q, op_d;
  logic              done;

  always_comb begin
    case (phase_q)
      PH_SETUP:  last = CNT_W'(SETUP_CYC - 1);
      PH_STROBE: last = CNT_W'(STROBE_CYC - 1);
      PH_HOLD:   last = CNT_W'(HOLD_CYC - 1);
      default:   last = '0;
    endcase
    done = (cnt_q == last);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    case (phase_q)
      PH_IDLE: begin
        if (launch) begin
          phase_d = PH_SETUP;
          cnt_d   = '0;
          op_d    = op_new;
        end
      end
      PH_SETUP: begin
        if (done) begin phase_d = PH_STROBE; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      end
      PH_STROBE: begin
        if (done) begin phase_d = PH_HOLD; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      end
      default: begin
        if (done) begin phase_d = PH_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
    end
  end

  assign phase  = phase_q;
  assign op_cur = op_q;
  assign busy   = (phase_q != PH_IDLE);
  assign cap_en = (phase_q == PH_STROBE) && done && op_q.is_read;

  // R2: an accepted start enters setup on the next clock
  p_launch_enters_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (phase_q == PH_SETUP));

  // R4: strobe phase is only ever entered from setup
  p_strobe_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE) |-> ($past(phase_q) == PH_SETUP));

  // R6: the register block never requests a launch mid-cycle
  p_no_launch_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> !launch);

  // R7: the captured operation stays frozen for the whole cycle
  p_op_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(op_q));
endmodule

// File: rtl/pcb_pins.sv
module pcb_pins
  import pcb_pkg::*;
(
  input  phase_e            phase,
  input  op_t               op_cur,
  output logic              cs_main_n,
  output logic              cs_sub_n,
  output logic              rs,
  output logic              wr_n,
  output logic              rd_n,
  output logic [PCB_DW-1:0] bus_out,
  output logic              bus_oe
);
  logic active, strobe, drive;

  always_comb begin
    active    = (phase != PH_IDLE);
    strobe    = (phase == PH_STROBE);
    drive     = active && !op_cur.is_read;
    cs_main_n = !(active && !op_cur.sub);
    cs_sub_n  = !(active && op_cur.sub);
    rs        = active && op_cur.rs;
    wr_n      = !(strobe && !op_cur.is_read);
    rd_n      = !(strobe && op_cur.is_read);
    bus_oe    = drive;
    bus_out   = drive ? op_cur.val : '0;
  end
endmodule

// File: rtl/panel_cmd_master.sv
module panel_cmd_master
  import pcb_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned STROBE_CYC = 3,
  parameter int unsigned HOLD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PCB_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [PCB_RW-1:0] reg_wdata,
  output logic [PCB_RW-1:0] reg_rdata,
  output logic              busy,
  output logic              cs_main_n,
  output logic              cs_sub_n,
  output logic              rs,
  output logic              wr_n,
  output logic              rd_n,
  output logic [PCB_DW-1:0] bus_out,
  output logic              bus_oe,
  input  logic [PCB_DW-1:0] bus_in
);
  logic   rst_s1, rst_s2;
  logic   launch, cap_en;
  op_t    op_new, op_cur;
  phase_e phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  pcb_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s2),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .cap_en   (cap_en),
    .cap_data (bus_in),
    .launch   (launch),
    .op_new   (op_new),
    .rdata    (reg_rdata)
  );

  pcb_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_s2),
    .launch (launch),
    .op_new (op_new),
    .phase  (phase),
    .op_cur (op_cur),
    .busy   (busy),
    .cap_en (cap_en)
  );

  pcb_pins u_pins (
    .phase     (phase),
    .op_cur    (op_cur),
    .cs_main_n (cs_main_n),
    .cs_sub_n  (cs_sub_n),
    .rs        (rs),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
  );

  // R2: a strobe pulse always addresses exactly one panel
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_s2)
    (!wr_n || !rd_n) |-> (cs_main_n != cs_sub_n));

  // R4: write and read strobes never overlap
  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_s2)
    !(!wr_n && !rd_n));

  // R8: the bus is released whenever the read strobe is low
  p_read_released_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    !rd_n |-> !bus_oe);
endmodule

// File: tb/panel_cmd_master_test.sv
`timescale 1ns/1ps
module panel_cmd_master_test;
  localparam int S = 2, W = 3, H = 2;
  localparam int TOT = S + W + H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, cs_main_n, cs_sub_n, rs, wr_n, rd_n, bus_oe;
  logic [17:0] bus_out;
  logic [17:0] bus_in = '0;

  int n_chk = 0, n_fail = 0;

  panel_cmd_master #(.SETUP_CYC(S), .STROBE_CYC(W), .HOLD_CYC(H)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .cs_main_n(cs_main_n), .cs_sub_n(cs_sub_n), .rs(rs), .wr_n(wr_n),
    .rd_n(rd_n), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  always #2.5 clk = ~clk;

  // bus monitor and panel model, sampled on the falling edge
  int n_busy = 0, n_wlow = 0, n_rlow = 0, n_wfall = 0, n_rfall = 0;
  int n_rd_oe = 0, n_nosetup = 0, n_nohold = 0, rk = 0;
  logic [17:0] rd_base = '0;
  logic [17:0] s_data = '0;
  logic s_rs = 0, s_csm = 1, s_css = 1, s_oe = 0;
  logic p_wr = 1, p_rd = 1, p_busy = 0;

  always @(negedge clk) begin
    if (busy) n_busy++;
    if (!wr_n) n_wlow++;
    if (!rd_n) n_rlow++;
    if (p_wr && !wr_n) begin
      n_wfall++; s_data = bus_out; s_rs = rs; s_csm = cs_main_n; s_css = cs_sub_n; s_oe = bus_oe;
    end
    if (p_rd && !rd_n) begin
      n_rfall++; s_rs = rs; s_csm = cs_main_n; s_css = cs_sub_n; s_oe = bus_oe;
    end
    if (!rd_n && bus_oe) n_rd_oe++;
    if (busy && !p_busy && (!wr_n || !rd_n)) n_nosetup++;
    if (!busy && p_busy && (!p_wr || !p_rd)) n_nohold++;
    if (!rd_n) begin rk++; bus_in = rd_base + 18'(rk); end
    else rk = 0;
    p_wr = wr_n; p_rd = rd_n; p_busy = busy;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] st;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 cs", {30'b0, cs_main_n, cs_sub_n}, 32'h3);
    chk("R1 strobes", {30'b0, wr_n, rd_n}, 32'h3);
    chk("R1 oe", 32'(bus_oe), 0);
    reg_read(3'd4, st);
    chk("R1 status", st, 0);
  endtask

  task automatic t_write_main();
    int b0, wl0, wf0, ns0, nh0;
    logic [31:0] st;
    reg_write(3'd0, 32'h1100_0000 | 32'h2A5C5);
    b0 = n_busy; wl0 = n_wlow; wf0 = n_wfall; ns0 = n_nosetup; nh0 = n_nohold;
    reg_write(3'd2, 32'h1);
    #1 st = reg_rdata;
    reg_read(3'd4, st);
    chk("R4 status busy", st, 32'h2);
    wait_idle();
    chk("R4 busy length", 32'(n_busy - b0), 32'(TOT));
    chk("R4 strobe length", 32'(n_wlow - wl0), 32'(W));
    chk("R4 setup/hold", 32'((n_nosetup - ns0) + (n_nohold - nh0)), 0);
    chk("R2 one pulse", 32'(n_wfall - wf0), 1);
    chk("R2 main cs", {30'b0, s_csm, s_css}, 32'h1);
    chk("R3 rs data", 32'(s_rs), 1);
    chk("R3 bus value", 32'(s_data), 32'h2A5C5);
    chk("R3 oe", 32'(s_oe), 1);
  endtask

  task automatic t_write_sub_index();
    int wf0;
    reg_write(3'd0, 32'h1000_0123);
    wf0 = n_wfall;
    reg_write(3'd2, 32'h3);
    wait_idle();
    chk("R2 sub pulse", 32'(n_wfall - wf0), 1);
    chk("R2 sub cs", {30'b0, s_csm, s_css}, 32'h2);
    chk("R3 rs index", 32'(s_rs), 0);
    chk("R3 bus index", 32'(s_data), 32'h123);
  endtask

  task automatic t_ignored();
    int wf0;
    reg_write(3'd0, 32'h0100_0055);
    wf0 = n_wfall;
    reg_write(3'd2, 32'h1);
    chk("R5 no write flag busy", 32'(busy), 0);
    reg_write(3'd0, 32'h1100_0055);
    reg_write(3'd2, 32'h2);
    chk("R5 go bit clear busy", 32'(busy), 0);
    repeat (TOT + 2) @(negedge clk);
    chk("R5 no pulses", 32'(n_wfall - wf0), 0);
  endtask

  task automatic t_busy_collide();
    int wf0;
    reg_write(3'd0, 32'h1100_0AAA);
    wf0 = n_wfall;
    reg_write(3'd2, 32'h1);
    reg_write(3'd0, 32'h1100_0555);
    reg_write(3'd2, 32'h3);
    wait_idle();
    chk("R6 busy start ignored", 32'(n_wfall - wf0), 1);
    chk("R7 latched value", 32'(s_data), 32'hAAA);
    chk("R7 latched panel", {30'b0, s_csm, s_css}, 32'h1);
    // start landing on the last hold clock
    wf0 = n_wfall;
    reg_write(3'd2, 32'h1);
    repeat (TOT - 2) @(negedge clk);
    reg_write(3'd2, 32'h1);
    chk("R6 last hold start ignored", 32'(busy), 0);
    reg_write(3'd2, 32'h1);
    chk("R6 next start accepted", 32'(busy), 1);
    wait_idle();
    chk("R6 two pulses", 32'(n_wfall - wf0), 2);
    chk("R7 new value used", 32'(s_data), 32'h555);
  endtask

  task automatic t_read();
    int rl0, rf0, oe0, wf0;
    logic [31:0] d;
    rd_base = 18'h10000;
    rl0 = n_rlow; rf0 = n_rfall; oe0 = n_rd_oe; wf0 = n_wfall;
    reg_write(3'd1, 32'h0100_0000);
    reg_write(3'd3, 32'h1);
    wait_idle();
    chk("R8 one read pulse", 32'(n_rfall - rf0), 1);
    chk("R4 read strobe length", 32'(n_rlow - rl0), 32'(W));
    chk("R8 rs high", 32'(s_rs), 1);
    chk("R8 main cs", {30'b0, s_csm, s_css}, 32'h1);
    chk("R8 bus released", 32'(n_rd_oe - oe0), 0);
    chk("R8 no write pulse", 32'(n_wfall - wf0), 0);
    reg_read(3'd1, d);
    chk("R9 read data", d, 32'h10000 + 32'(W));
    rd_base = 18'h3FF00;
    reg_write(3'd1, 32'h0100_0000);
    reg_write(3'd3, 32'h3);
    wait_idle();
    chk("R8 sub cs", {30'b0, s_csm, s_css}, 32'h2);
    reg_read(3'd1, d);
    chk("R9 read data sub", d, 32'h3FF00 + 32'(W));
    rf0 = n_rfall;
    rd_base = 18'h00111;
    reg_write(3'd3, 32'h1);
    chk("R8 unarmed ignored", 32'(busy), 0);
    repeat (TOT + 2) @(negedge clk);
    chk("R8 no read pulse", 32'(n_rfall - rf0), 0);
    reg_read(3'd1, d);
    chk("R9 data kept", d, 32'h3FF00 + 32'(W));
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_main();
    t_write_sub_index();
    t_ignored();
    t_busy_collide();
    t_read();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule